// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Dual Alarms

This core keeps time for a chip from a slow 32.768 kHz clock enable. A programmable prescaler turns that enable into a tick of 16 Hz at the default divider setting. Each tick advances a 32-bit counter whose low four bits are a fraction of a second, so bits 31 to 4 hold whole seconds. Two compare registers raise sticky alarm flags when the running count reaches them. A periodic flag marks every whole-second boundary. Flags are cleared by writing a one to them. A single level interrupt output is high while any flag is set and its enable is also set.

Software reaches the core through a synchronous 32-bit register port. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the read strobe. One scratch word is kept for software, for example to hold an epoch count across counter wraps. A clock-select register gates the prescaler: only the code 3 lets it run.

Top module: `rtc_core`

## Requirements
- R1: The register map uses these byte offsets: 0x00 counter, 0x04 first alarm, 0x08 status, 0x0C divider, 0x14 deep-control word, 0x18 second alarm, 0x1C clock select, 0x40 scratch. Read data appears on `rdata` the cycle after `rd_en`. Unmapped offsets read as zero.
- R2: While clock select holds 3, a tick occurs once every 2×(DIV+1) cycles in which `slow_en` is high. Any other code stops the ticks and clears the prescaler.
- R3: Each tick adds one to the counter, and 0xFFFFFFFF wraps to 0. A counter write loads the value directly and takes priority over a tick in the same cycle.
- R4: Alarm flag 0 (status bit 0) sets only when its enable (bit 2) is 1 and a tick makes the counter equal to alarm 0. Alarm flag 1 (bit 4) works the same way with its enable (bit 6) and alarm 1.
- R5: The seconds flag (bit 1) sets on each tick that wraps the four fraction bits from 0xF to 0x0. Its enable is bit 3.
- R6: Writing status clears each flag whose bit is written as 1 and leaves flags written as 0 unchanged. The enables at bits 2, 3 and 6 are plain read/write bits. Bits 5 and 7 and above read as zero.
- R7: When a flag is set by an event and cleared by a write in the same cycle, the flag ends up set.
- R8: `irq` is high exactly while some flag and its matching enable are both 1.
- R9: The scratch and deep-control words store whatever is written to them, and the logic never changes them.
- R10: Reset clears the counter, both alarms, status and clock select, and loads the divider with 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
A write takes effect at the edge that samples it, and read data is due one edge after the read strobe. The monitor therefore compares each queued expectation at the falling edge after the capturing rising edge. A counter run starts with the clock-select write at a known edge, so with divider 1 the ticks land on the 4th, 8th and later edges after it. Each run ends with a write that removes clock select at a chosen edge, which makes the final count and flags exact. The same-cycle set-and-clear case times a status write to land on the very edge of a tick.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int XW      = 32,
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int SELW    = 4,
  parameter int DIV_RST = 1023,
  parameter int SEL_ON  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [XW-1:0] wdata,
  output logic [XW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CNT = AW'(8'h00), A_AL0 = AW'(8'h04), A_ST = AW'(8'h08),
    A_DIV = AW'(8'h0C), A_DEEP = AW'(8'h14), A_AL1 = AW'(8'h18), A_SEL = AW'(8'h1C),
    A_SW = AW'(8'h40);

  logic [XW-1:0]   cnt, alm0, alm1, deep, swv;
  logic [DW-1:0]   divr, pcnt;
  logic [SELW-1:0] sel;
  logic            phase, a0f, hzf, a1f, a0e, hze, a1e;

  wire wcnt  = wr_en && addr == A_CNT;
  wire wst   = wr_en && addr == A_ST;
  wire wswv  = wr_en && addr == A_SW;
  wire run   = sel == SELW'(SEL_ON);
  wire pwrap = run && slow_en && pcnt >= divr;
  wire tick  = pwrap && phase;
  wire step  = tick && !wcnt;
  wire [XW-1:0] cnt_nx = cnt + 1'b1;

  wire set_a0 = step && a0e && cnt_nx == alm0;
  wire set_a1 = step && a1e && cnt_nx == alm1;
  wire set_hz = step && cnt[3:0] == 4'hF;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt  <= '0;
      phase <= 1'b0;
    end else if (slow_en) begin
      if (pwrap) begin
        pcnt  <= '0;
        phase <= ~phase;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      alm0 <= '0;
      alm1 <= '0;
      divr <= DW'(DIV_RST);
      sel  <= '0;
      deep <= '0;
      swv  <= '0;
      {a0f, hzf, a1f, a0e, hze, a1e} <= '0;
    end else begin
      if (wcnt)      cnt <= wdata;
      else if (tick) cnt <= cnt_nx;
      if (wr_en && addr == A_AL0)  alm0 <= wdata;
      if (wr_en && addr == A_AL1)  alm1 <= wdata;
      if (wr_en && addr == A_DIV)  divr <= wdata[DW-1:0];
      if (wr_en && addr == A_SEL)  sel  <= wdata[SELW-1:0];
      if (wr_en && addr == A_DEEP) deep <= wdata;
      if (wswv)                    swv  <= wdata;
      a0f <= set_a0 | (a0f & ~(wst & wdata[0]));
      hzf <= set_hz | (hzf & ~(wst & wdata[1]));
      a1f <= set_a1 | (a1f & ~(wst & wdata[4]));
      if (wst) {a1e, hze, a0e} <= {wdata[6], wdata[3], wdata[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CNT:   rdata <= cnt;
        A_AL0:   rdata <= alm0;
        A_ST:    rdata <= XW'({a1e, 1'b0, a1f, hze, a0e, hzf, a0f});
        A_DIV:   rdata <= XW'(divr);
        A_DEEP:  rdata <= deep;
        A_AL1:   rdata <= alm1;
        A_SEL:   rdata <= XW'(sel);
        A_SW:    rdata <= swv;
        default: rdata <= '0;
      endcase
    end
  end

  assign irq = (a0f & a0e) | (hzf & hze) | (a1f & a1e);
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(parameter int XW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run,
  input logic          wcnt,
  input logic [XW-1:0] cnt,
  input logic          wswv,
  input logic [XW-1:0] swv,
  input logic          a0f,
  input logic          a0e,
  input logic          wst,
  input logic          wbit0
);
  p_tick_gated_r2: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !tick);
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wcnt) |=> cnt == $past(cnt) + 1'b1);
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wcnt) |=> $stable(cnt));
  p_alarm_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a0f) |-> $past(a0e));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a0f && !(wst && wbit0)) |=> a0f);
  p_scratch_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wswv |=> $stable(swv));
endmodule

bind rtc_core rtc_core_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wcnt(wcnt), .cnt(cnt),
  .wswv(wswv), .swv(swv), .a0f(a0f), .a0e(a0e), .wst(wst), .wbit0(wdata[0])
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, slow_en = 1, wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rd_q = 0;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  rtc_core dut_i (.clk(clk), .rst_n(rst_n), .slow_en(slow_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq %b expected %b", t, irq, e);
    end
  endtask

  task automatic run_for(input int m);
    wr(8'h1C, 32'h3);
    repeat (m) @(negedge clk);
    wr(8'h1C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, 32'h0, "R10 counter reset");
    rd(8'h04, 32'h0, "R10 alarm0 reset");
    rd(8'h18, 32'h0, "R10 alarm1 reset");
    rd(8'h08, 32'h0, "R10 status reset");
    rd(8'h0C, 32'd1023, "R10 divider reset");
    rd(8'h1C, 32'h0, "R10 clock select reset");
    chk_irq(0, "R8 irq after reset");

    wr(8'h40, 32'hDEADBEEF);
    wr(8'h14, 32'h0000A5A5);
    rd(8'h40, 32'hDEADBEEF, "R9 scratch");
    rd(8'h14, 32'h0000A5A5, "R9 deep word");
    rd(8'h20, 32'h0, "R1 unmapped offset");

    wr(8'h0C, 32'd1);
    rd(8'h0C, 32'd1, "R1 divider write");
    wr(8'h00, 32'h0000000E);
    wr(8'h04, 32'h00000010);
    wr(8'h08, 32'h0000000C);
    run_for(10);
    rd(8'h00, 32'h10, "R2 R3 two ticks at period 4");
    rd(8'h08, 32'h0F, "R4 R5 alarm0 and seconds flags");
    chk_irq(1, "R8 irq with enabled flags");

    wr(8'h08, 32'h0000000D);
    rd(8'h08, 32'h0E, "R6 clear alarm0 only");
    wr(8'h08, 32'h0000000E);
    rd(8'h08, 32'h0C, "R6 clear seconds flag");
    chk_irq(0, "R8 irq after clears");

    wr(8'h18, 32'h00000014);
    run_for(18);
    rd(8'h00, 32'h14, "R3 four ticks");
    rd(8'h08, 32'h0C, "R4 disabled alarm1 stays clear");
    wr(8'h18, 32'h00000018);
    wr(8'h08, 32'h0000004C);
    run_for(18);
    rd(8'h08, 32'h5C, "R4 alarm1 flag");
    chk_irq(1, "R8 irq from alarm1");

    wr(8'h0C, 32'd2);
    run_for(13);
    rd(8'h00, 32'h1A, "R2 period 6 with divider 2");
    wr(8'h0C, 32'd1);

    wr(8'h1C, 32'h2);
    repeat (20) @(negedge clk);
    rd(8'h00, 32'h1A, "R2 reserved select stops ticks");
    rd(8'h1C, 32'h2, "R1 select readback");
    wr(8'h1C, 32'h0);

    wr(8'h00, 32'hFFFFFFFE);
    rd(8'h00, 32'hFFFFFFFE, "R3 counter load");
    wr(8'h08, 32'h0000005F);
    rd(8'h08, 32'h4C, "R6 clear all flags");
    run_for(10);
    rd(8'h00, 32'h0, "R3 wrap to zero");
    rd(8'h08, 32'h4E, "R5 seconds flag on wrap");

    wr(8'h08, 32'h0000004E);
    wr(8'h00, 32'h0000000F);
    wr(8'h1C, 32'h3);
    repeat (3) @(negedge clk);
    wr(8'h08, 32'h0000004E);
    wr(8'h1C, 32'h0);
    rd(8'h08, 32'h4F, "R7 set wins over clear");
    rd(8'h00, 32'h10, "R3 tick during status write");
    rd(8'h40, 32'hDEADBEEF, "R9 scratch untouched");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule